// File: doc/BRIEF.md
# Recency Stack with Selectable Fill Position

This block holds the replacement state of one set in a set-associative cache. The state is an ordered list of way indices, running from most recently used (MRU) to least recently used (LRU). A cache controller reports each lookup to the block. On a hit, the block moves the touched way to the MRU end. On a miss, the block names the way at the LRU end as the victim.

The controller then chooses where the refilled way lands, using a two-bit mode input and a one-bit reuse hint. It can always go to MRU (classic LRU behaviour) or always stay at LRU. It can follow the reuse hint. It can follow a bimodal rule, which sends low-reuse fills to MRU only rarely. The bimodal rule lets part of a large, cycling working set stay resident instead of flushing the whole set. Tags, data and the reuse predictor itself live outside the block.

Top module: `recency_stack`

## Requirements
- R1: A synchronous reset loads the order with way i at position i. Position 0 is MRU and position WAYS-1 is LRU. Position i occupies `stack_order[i*3 +: 3]`.
- R2: The positions always hold each way index exactly once.
- R3: A valid hit moves `hit_way` to position 0. Every entry that was nearer MRU than the hit way's old position moves one place toward LRU. Entries further toward LRU stay where they are.
- R4: `victim_way` shows the way at the LRU position in the same cycle, so it is valid combinationally during a miss request.
- R5: Mode 2'b00 (MRU fill) affects a valid miss as follows. The victim moves to position 0, and all other entries shift one place toward LRU.
- R6: In mode 2'b01 (LRU fill), a valid miss leaves the order unchanged, because the victim already sits at LRU.
- R7: Mode 2'b11 (hinted fill) places a missed block according to the reuse hint. With `reuse_hi`=1 the fill goes to MRU, as in R5. With `reuse_hi`=0 the fill stays at LRU, as in R6.
- R8: Mode 2'b10 (bimodal fill) places a missed block in one of two ways. With `reuse_hi`=1 the fill goes to MRU. With `reuse_hi`=0 the fill goes to MRU only when bits [4:0] of an internal 16-bit LFSR are all zero, and stays at LRU otherwise. The LFSR resets to 16'h0001 and advances on every clock edge out of reset, whether or not there is an access. Each step shifts left and brings in bit15^bit13^bit12^bit10 at bit 0. The value sampled is the one present in the access cycle.
- R9: When `acc_valid` is 0, the order does not change, whatever the other inputs are.
- R10: For a hit, `ins_mode` and `reuse_hi` have no effect. Only R3 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access to this set is presented this cycle |
| acc_hit | input | 1 | The access hit (1) or missed (0) |
| hit_way | input | 3 | Way that hit |
| ins_mode | input | 2 | Fill position rule for misses |
| reuse_hi | input | 1 | Reuse hint for the missed block |
| victim_way | output | 3 | Way to replace on a miss |
| stack_order | output | 24 | Packed order, position 0 (MRU) in the low bits |

## Verification
The bench builds the block with its defaults: eight ways and a five-bit bimodal mask. With eight ways, random hits land on every stack position, including the MRU and LRU ends. With a 1-in-32 bimodal chance, a few hundred low-reuse misses produce many MRU fills, which the model predicts cycle-exactly from its own LFSR. A mid-run reset is also applied, to confirm that both the order and the LFSR restart.

// File: rtl/recency_stack.sv
module recency_stack #(
  parameter int WAYS = 8,
  parameter int BIM_BITS = 5,
  parameter logic [15:0] LFSR_SEED = 16'h0001
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          acc_valid,
  input  logic                          acc_hit,
  input  logic [$clog2(WAYS)-1:0]       hit_way,
  input  logic [1:0]                    ins_mode,
  input  logic                          reuse_hi,
  output logic [$clog2(WAYS)-1:0]       victim_way,
  output logic [WAYS*$clog2(WAYS)-1:0]  stack_order
);
  localparam int IW = $clog2(WAYS);

  logic [IW-1:0] ord [WAYS];
  logic [15:0]   lfsr;
  logic [IW-1:0] hit_pos, src_pos, mover;
  logic          mru_fill, move;

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < WAYS; i++)
      if (ord[i] == hit_way) hit_pos = IW'(i);
  end

  always_comb begin
    case (ins_mode)
      2'b00:   mru_fill = 1'b1;
      2'b01:   mru_fill = 1'b0;
      2'b10:   mru_fill = reuse_hi | (lfsr[BIM_BITS-1:0] == '0);
      default: mru_fill = reuse_hi;
    endcase
  end

  assign victim_way = ord[WAYS-1];
  assign move       = acc_valid & (acc_hit | mru_fill);
  assign src_pos    = acc_hit ? hit_pos : IW'(WAYS-1);
  assign mover      = acc_hit ? hit_way : ord[WAYS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= LFSR_SEED;
      for (int i = 0; i < WAYS; i++) ord[i] <= IW'(i);
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (move) begin
        ord[0] <= mover;
        for (int i = 1; i < WAYS; i++)
          if (i <= int'(src_pos)) ord[i] <= ord[i-1];
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_pack
    assign stack_order[g*IW +: IW] = ord[g];
  end
endmodule

// File: rtl/recency_stack_chk.sv
module recency_stack_chk #(
  parameter int WAYS = 8,
  parameter int IW = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_valid,
  input logic                 acc_hit,
  input logic [IW-1:0]        hit_way,
  input logic [1:0]           ins_mode,
  input logic                 reuse_hi,
  input logic [IW-1:0]        victim_way,
  input logic [WAYS*IW-1:0]   stack_order
);
  logic [WAYS-1:0]    seen;
  logic [WAYS*IW-1:0] init_vec;

  always_comb begin
    seen = '0;
    init_vec = '0;
    for (int i = 0; i < WAYS; i++) begin
      seen[stack_order[i*IW +: IW]] = 1'b1;
      init_vec[i*IW +: IW] = IW'(i);
    end
  end

  a_r1_reset_order: assert property (@(posedge clk)
    $past(rst) |-> stack_order == init_vec);

  a_r2_permutation: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == WAYS);

  a_r3_hit_to_mru: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_hit |=> stack_order[IW-1:0] == $past(hit_way));

  a_r5_mru_fill: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b00 |=> stack_order[IW-1:0] == $past(victim_way));

  a_r6_lru_fill: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b01 |=> $stable(stack_order));

  a_r7_hint_low: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b11 && !reuse_hi |=> $stable(stack_order));

  a_r7_hint_high: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b11 && reuse_hi |=> stack_order[IW-1:0] == $past(victim_way));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(stack_order));
endmodule

bind recency_stack recency_stack_chk #(.WAYS(WAYS), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .hit_way(hit_way), .ins_mode(ins_mode), .reuse_hi(reuse_hi),
  .victim_way(victim_way), .stack_order(stack_order)
);

// File: tb/recency_stack_tb.sv
`timescale 1ns/1ps
module recency_stack_tb;
  localparam int WAYS = 8;
  localparam int IW = 3;

  logic clk = 0, rst = 1, acc_valid = 0, acc_hit = 0, reuse_hi = 0;
  logic [IW-1:0] hit_way = '0;
  logic [1:0] ins_mode = '0;
  wire  [IW-1:0] victim_way;
  wire  [WAYS*IW-1:0] stack_order;

  int total = 0, bad = 0;
  int q[$];
  logic [15:0] lm;

  recency_stack u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .hit_way(hit_way), .ins_mode(ins_mode), .reuse_hi(reuse_hi),
    .victim_way(victim_way), .stack_order(stack_order)
  );

  always #4 clk = ~clk;

  function automatic logic [WAYS*IW-1:0] model_vec();
    logic [WAYS*IW-1:0] v;
    for (int i = 0; i < WAYS; i++) v[i*IW +: IW] = IW'(q[i]);
    return v;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic perm_chk();
    logic [WAYS-1:0] m = '0;
    for (int i = 0; i < WAYS; i++) m[stack_order[i*IW +: IW]] = 1'b1;
    chk("R2", 64'(m), 64'({WAYS{1'b1}}));
  endtask

  task automatic model_reset();
    q = {};
    for (int i = 0; i < WAYS; i++) q.push_back(i);
    lm = 16'h0001;
  endtask

  task automatic do_reset();
    rst = 1;
    acc_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
    chk("R1", 64'(stack_order), 64'(model_vec()));
  endtask

  task automatic step(bit v, bit h, int w, logic [1:0] m, bit r);
    string tag;
    bit mru;
    int x;
    acc_valid = v; acc_hit = h; hit_way = IW'(w); ins_mode = m; reuse_hi = r;
    #1;
    if (v && !h) chk("R4", 64'(victim_way), 64'(q[WAYS-1]));
    if (!v) tag = "R9";
    else if (h) tag = (m != 2'b00 || r) ? "R10" : "R3";
    else case (m)
      2'b00: tag = "R5";
      2'b01: tag = "R6";
      2'b10: tag = "R8";
      default: tag = "R7";
    endcase
    if (v && h) begin
      for (int i = 0; i < WAYS; i++)
        if (q[i] == w) begin x = i; break; end
      q.delete(x);
      q.push_front(w);
    end else if (v) begin
      mru = (m == 2'b00) || (m == 2'b11 && r) || (m == 2'b10 && (r || lm[4:0] == 5'd0));
      if (mru) begin
        x = q.pop_back();
        q.push_front(x);
      end
    end
    @(posedge clk);
    lm = {lm[14:0], lm[15] ^ lm[13] ^ lm[12] ^ lm[10]};
    @(negedge clk);
    chk(tag, 64'(stack_order), 64'(model_vec()));
    perm_chk();
  endtask

  initial begin
    #(8ns * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    step(0, 1, 5, 2'b00, 1);
    step(0, 0, 2, 2'b10, 1);
    step(1, 1, 3, 2'b00, 0);
    step(1, 1, 7, 2'b00, 0);
    step(1, 1, 7, 2'b00, 0);
    step(1, 1, 0, 2'b01, 1);
    for (int k = 0; k < 3; k++) step(1, 0, 0, 2'b00, 0);
    for (int k = 0; k < 2; k++) step(1, 0, 0, 2'b01, 1);
    step(1, 0, 0, 2'b11, 1);
    step(1, 0, 0, 2'b11, 0);
    step(1, 0, 0, 2'b10, 1);
    for (int k = 0; k < 400; k++) step(1, 0, 0, 2'b10, 0);
    for (int k = 0; k < 60; k++) step(1, 1, k % WAYS, 2'(k % 4), k[0]);
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, WAYS-1), 2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
    do_reset();
    for (int k = 0; k < 100; k++) step(1, 0, 0, 2'b10, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule